// File: doc/BRIEF.md
# Programmable Wait-State Cycle Calculator

This block tells a bus master how many bus cycles a memory access costs, and then counts those cycles out. A request carries the address page (address bits [27:24]), a flag that marks the access as sequential or non-sequential, and a width code. The block looks the cost up in an internal table, holds the cost on its output and raises a one-cycle done pulse once that many clock edges have gone by. The memories are not part of this block.

Most pages have fixed costs. The three cartridge windows and the save-RAM area have costs that come from a wait-control word. Writing that word refills the whole table in a single clock edge. A 32-bit cartridge access is charged as two 16-bit accesses.

Top module: `ws_cycle_calc`

## Requirements
- R1: During and after reset, `busy` and `done` are low. The table holds the costs derived from the parameter `RESET_CFG`, which is 0 by default: at that default a non-sequential 16-bit access to page 8 costs 5.
- R2: Pages 0, 1, 3 and 4 cost 1 cycle for every width and for both sequential and non-sequential accesses.
- R3: Page 2 (external work RAM) costs 6 for a 32-bit access and 3 for an 8-bit or 16-bit access, whether sequential or not.
- R4: Pages 5, 6 and 7 cost 2 for a 32-bit access and 1 otherwise.
- R5: The cartridge windows are W0 (pages 8 and 9), W1 (pages A and B) and W2 (pages C and D). Their 16-bit costs come from fields of `cfg_data`. The first-access fields are W0 = [3:2], W1 = [6:5] and W2 = [9:8]. The second-access bits are W0 = [4], W1 = [7] and W2 = [10]. The non-sequential cost is 1 + {4,3,2,8}[first]. The sequential cost is 2 when the second bit is 1; when the bit is 0 it is 3 for W0, 5 for W1 and 9 for W2.
- R6: For a 32-bit cartridge access, the non-sequential cost is the 16-bit non-sequential cost plus the 16-bit sequential cost. The sequential cost is twice the 16-bit sequential cost.
- R7: Both pages of a cartridge window cost the same. Pages E and F (save RAM) cost 1 + {4,3,2,8}[cfg_data[1:0]] for every width and sequentiality.
- R8: Width code 0 is 8-bit, 1 is 16-bit, and 2 and 3 are 32-bit. An 8-bit access costs the same as a 16-bit access.
- R9: A `cfg_we` pulse rewrites the table at that clock edge. A request accepted at that same edge uses the old costs. A request accepted at any later edge uses the new costs.
- R10: A request is accepted at an edge where `req_valid` is high and `busy` is low. `cost` then takes the looked-up value N, and `busy` rises. `done` is high for exactly the cycle that follows the N-th edge after acceptance, and `busy` falls at that same edge.
- R11: While `busy` is high, `req_valid` is ignored: `cost` stays the same and the running count is not restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Write strobe for the wait-control word |
| cfg_data | input | 11 | Wait-control word (field positions in R5 and R7) |
| req_valid | input | 1 | Access request |
| req_page | input | 4 | Address bits [27:24] of the access |
| req_seq | input | 1 | 1 = sequential, 0 = non-sequential |
| req_width | input | 2 | Width code (R8) |
| busy | output | 1 | A counted access is in progress |
| done | output | 1 | One-cycle pulse when the count ends |
| cost | output | 5 | Cycle cost of the accepted request |

## Verification
The bench sweeps the width codes across every cost class and across several wait-control words. A design with a bad field map or a bad wait list would then report a wrong count for one window, and a 32-bit cartridge access built as double the non-sequential cost would show up at once. Each window is checked on both of its pages, so a decoder that splits the pair is caught. The bench writes a new word on the same edge that a request is accepted, which exposes a table that forwards the incoming word too early. It also sends a request in the middle of a count, which catches a counter that reloads and would move the done pulse.

// File: rtl/ws_pkg.sv
// Package: shared widths, cost entry type and the cost formulae.
// Assumes a 4-bit page index and costs that fit the COST_W field (max 18).
package ws_pkg;
    parameter int PAGE_W  = 4;
    parameter int COST_W  = 5;
    parameter int CFG_W   = 11;
    parameter int WIDTH_W = 2;
    localparam int NPAGES = 1 << PAGE_W;

    // Field positions inside the wait-control word
    localparam int SRAM_LSB = 0;
    localparam int W0_LSB   = 2;
    localparam int WIN_STEP = 3;

    typedef struct packed {
        logic [COST_W-1:0] n16;
        logic [COST_W-1:0] s16;
        logic [COST_W-1:0] n32;
        logic [COST_W-1:0] s32;
    } cost_set_t;

    // Extra waits selected by a 2-bit first-access field
    function automatic logic [COST_W-1:0] first_wait(input logic [1:0] f);
        case (f)
            2'd0:    return COST_W'(4);
            2'd1:    return COST_W'(3);
            2'd2:    return COST_W'(2);
            default: return COST_W'(8);
        endcase
    endfunction

    // Full cost set of one page for a given wait-control word
    function automatic cost_set_t page_costs(input logic [PAGE_W-1:0] pg,
                                             input logic [CFG_W-1:0]  c);
        cost_set_t r;
        logic [1:0] win;
        logic [1:0] fst;
        logic       snd;
        logic [COST_W-1:0] slow;
        r   = '{n16: COST_W'(1), s16: COST_W'(1), n32: COST_W'(1), s32: COST_W'(1)};
        win = 2'((pg - PAGE_W'(8)) >> 1);
        fst = c[W0_LSB + WIN_STEP*win +: 2];
        snd = c[W0_LSB + WIN_STEP*win + 2];
        case (win)
            2'd0:    slow = COST_W'(2);
            2'd1:    slow = COST_W'(4);
            default: slow = COST_W'(8);
        endcase
        case (pg)
            4'h2: r = '{n16: COST_W'(3), s16: COST_W'(3), n32: COST_W'(6), s32: COST_W'(6)};
            4'h5, 4'h6, 4'h7:
                r = '{n16: COST_W'(1), s16: COST_W'(1), n32: COST_W'(2), s32: COST_W'(2)};
            4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hD: begin
                r.n16 = COST_W'(1) + first_wait(fst);
                r.s16 = COST_W'(1) + (snd ? COST_W'(1) : slow);
                r.n32 = r.n16 + r.s16;
                r.s32 = r.s16 << 1;
            end
            4'hE, 4'hF: begin
                r.n16 = COST_W'(1) + first_wait(c[SRAM_LSB +: 2]);
                r.s16 = r.n16;
                r.n32 = r.n16;
                r.s32 = r.n16;
            end
            default: ;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/ws_cost_table.sv
// Cost table: one registered cost set per page. The table is refilled
// from the incoming word on a write edge. The lookup is combinational,
// so it sees the old contents on the write cycle itself.
module ws_cost_table
    import ws_pkg::*;
#(
    parameter logic [CFG_W-1:0] RESET_CFG = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [CFG_W-1:0]   wr_cfg,
    input  logic [PAGE_W-1:0]  lk_page,
    input  logic               lk_seq,
    input  logic [WIDTH_W-1:0] lk_width,
    output logic [COST_W-1:0]  lk_cost
);
    cost_set_t tbl [NPAGES];

    for (genvar p = 0; p < NPAGES; p++) begin : g_page
        // Refill this page's entry at reset or on a control write
        always_ff @(posedge clk) begin
            if (!rst_n)
                tbl[p] <= page_costs(PAGE_W'(p), RESET_CFG);
            else if (wr_en)
                tbl[p] <= page_costs(PAGE_W'(p), wr_cfg);
        end
    end

    cost_set_t sel;
    logic      wide;

    // Pick the entry for the page, then the column for width and sequentiality
    always_comb begin
        sel  = tbl[lk_page];
        wide = lk_width[1];
        if (wide)
            lk_cost = lk_seq ? sel.s32 : sel.n32;
        else
            lk_cost = lk_seq ? sel.s16 : sel.n16;
    end
endmodule

// File: rtl/ws_countdown.sv
// Countdown timer: it accepts a cost while idle and pulses done after
// that many edges. Assumes a loaded cost of at least 1.
module ws_countdown
    import ws_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [COST_W-1:0] load,
    output logic              busy,
    output logic              done,
    output logic [COST_W-1:0] cost
);
    logic [COST_W-1:0] cnt;

    // Load on acceptance, count down while busy, pulse done at the end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
            cost <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    cnt  <= load;
                    cost <= load;
                    busy <= 1'b1;
                end
            end else if (cnt == COST_W'(1)) begin
                busy <= 1'b0;
                done <= 1'b1;
            end else begin
                cnt <= cnt - COST_W'(1);
            end
        end
    end
endmodule

// File: rtl/ws_cycle_calc.sv
// Top: wait-state cycle calculator. A control write refills the cost
// table. Each accepted request is charged its table cost, and done
// pulses after that many edges. Requests made while busy are dropped.
module ws_cycle_calc
    import ws_pkg::*;
#(
    parameter logic [CFG_W-1:0] RESET_CFG = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CFG_W-1:0]   cfg_data,
    input  logic               req_valid,
    input  logic [PAGE_W-1:0]  req_page,
    input  logic               req_seq,
    input  logic [WIDTH_W-1:0] req_width,
    output logic               busy,
    output logic               done,
    output logic [COST_W-1:0]  cost
);
    logic [COST_W-1:0] lk_cost;
    logic              accept;

    ws_cost_table #(.RESET_CFG(RESET_CFG)) i_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_cfg   (cfg_data),
        .lk_page  (req_page),
        .lk_seq   (req_seq),
        .lk_width (req_width),
        .lk_cost  (lk_cost)
    );

    // A request starts the timer only while it is idle
    assign accept = req_valid && !busy;

    ws_countdown i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .load  (lk_cost),
        .busy  (busy),
        .done  (done),
        .cost  (cost)
    );
endmodule

// File: rtl/ws_cycle_calc_chk.sv
// Checker for ws_cycle_calc. It watches only the top-level ports and is
// attached through bind.
module ws_cycle_calc_chk
    import ws_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [PAGE_W-1:0]  req_page,
    input logic               req_seq,
    input logic [WIDTH_W-1:0] req_width,
    input logic               busy,
    input logic               done,
    input logic [COST_W-1:0]  cost
);
    // R1: outputs are idle right after reset is released
    assert_reset_idle_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!busy && !done));

    // R10: an accepted request makes the block busy
    assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy);

    // R10: done never overlaps a running count
    assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10: a running count always carries a nonzero cost
    assert_cost_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cost != '0));

    // R11: cost cannot change while busy
    assert_cost_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(cost));

    // R3: a 32-bit access to page 2 is charged 6
    assert_ewram_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_page == 4'h2 && req_width[1]) |=> (cost == COST_W'(6)));

    // R2: page 0 is charged 1
    assert_default_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && req_page == 4'h0) |=> (cost == COST_W'(1)));
endmodule

bind ws_cycle_calc ws_cycle_calc_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_page  (req_page),
    .req_seq   (req_seq),
    .req_width (req_width),
    .busy      (busy),
    .done      (done),
    .cost      (cost)
);

// File: tb/test_ws_cycle_calc.sv
`timescale 1ns/1ps
module test_ws_cycle_calc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [10:0] cfg_data = '0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_page = '0;
    logic        req_seq = 1'b0;
    logic [1:0]  req_width = '0;
    logic        busy, done;
    logic [4:0]  cost;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ws_cycle_calc i_ws_cycle_calc (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data),
        .req_valid(req_valid), .req_page(req_page), .req_seq(req_seq),
        .req_width(req_width), .busy(busy), .done(done), .cost(cost)
    );

    // {cfg[10:0], page[3:0], seq, width[1:0], expected cost[4:0]}
    localparam int NV = 28;
    localparam logic [22:0] VEC [NV] = '{
        {11'h000, 4'h0, 1'b0, 2'd2, 5'd1},
        {11'h000, 4'h1, 1'b1, 2'd0, 5'd1},
        {11'h000, 4'h2, 1'b0, 2'd2, 5'd6},
        {11'h000, 4'h2, 1'b1, 2'd0, 5'd3},
        {11'h000, 4'h2, 1'b1, 2'd1, 5'd3},
        {11'h000, 4'h5, 1'b0, 2'd2, 5'd2},
        {11'h000, 4'h7, 1'b1, 2'd1, 5'd1},
        {11'h000, 4'h6, 1'b0, 2'd3, 5'd2},
        {11'h000, 4'h8, 1'b0, 2'd1, 5'd5},
        {11'h000, 4'h9, 1'b1, 2'd1, 5'd3},
        {11'h000, 4'h8, 1'b0, 2'd2, 5'd8},
        {11'h000, 4'h9, 1'b1, 2'd2, 5'd6},
        {11'h000, 4'hD, 1'b1, 2'd2, 5'd18},
        {11'h000, 4'hA, 1'b1, 2'd0, 5'd5},
        {11'h000, 4'hF, 1'b1, 2'd2, 5'd5},
        {11'h01C, 4'h8, 1'b0, 2'd1, 5'd9},
        {11'h01C, 4'h9, 1'b1, 2'd2, 5'd4},
        {11'h01C, 4'h8, 1'b0, 2'd2, 5'd11},
        {11'h002, 4'hE, 1'b0, 2'd2, 5'd3},
        {11'h0A0, 4'hB, 1'b0, 2'd2, 5'd6},
        {11'h0A0, 4'hA, 1'b1, 2'd1, 5'd2},
        {11'h600, 4'hC, 1'b0, 2'd1, 5'd3},
        {11'h600, 4'hD, 1'b1, 2'd2, 5'd4},
        {11'h600, 4'h3, 1'b0, 2'd2, 5'd1},
        {11'h7FF, 4'hE, 1'b1, 2'd0, 5'd9},
        {11'h7FF, 4'h4, 1'b0, 2'd2, 5'd1},
        {11'h000, 4'hC, 1'b0, 2'd0, 5'd5},
        {11'h000, 4'hB, 1'b0, 2'd1, 5'd5}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [3:0] pg, input logic [1:0] w);
        if (pg == 4'h2) return "R3";
        if (pg >= 4'h5 && pg <= 4'h7) return "R4";
        if (pg >= 4'h8 && pg <= 4'hD) return w[1] ? "R6" : "R5";
        if (pg >= 4'hE) return "R7";
        return "R2";
    endfunction

    task automatic write_cfg(input logic [10:0] c);
        @(negedge clk);
        cfg_we = 1'b1; cfg_data = c;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Issue a request (optionally with a same-edge write) and count edges to done
    task automatic issue(input bit we, input logic [10:0] c, input logic [3:0] pg,
                         input logic sq, input logic [1:0] w, output int n);
        @(negedge clk);
        req_valid = 1'b1; req_page = pg; req_seq = sq; req_width = w;
        cfg_we = we; cfg_data = c;
        @(negedge clk);
        req_valid = 1'b0; cfg_we = 1'b0;
        n = 0;
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check(!busy && !done, "R1 idle in reset", int'({busy, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done, "R1 idle after reset", int'({busy, done}), 0);
        issue(1'b0, 11'h000, 4'h8, 1'b0, 2'd1, n);
        check(n == 5, "R1 reset table", n, 5);

        for (int i = 0; i < NV; i++) begin
            logic [22:0] v;
            v = VEC[i];
            write_cfg(v[22:12]);
            issue(1'b0, 11'h000, v[11:8], v[7], v[6:5], n);
            check(n == int'(v[4:0]), tag_of(v[11:8], v[6:5]), n, int'(v[4:0]));
            check(cost == v[4:0], tag_of(v[11:8], v[6:5]), int'(cost), int'(v[4:0]));
        end

        // R8: byte and half cost the same, code 3 acts as a word
        write_cfg(11'h000);
        issue(1'b0, 11'h000, 4'hC, 1'b1, 2'd0, n);
        check(n == 9, "R8 byte", n, 9);
        issue(1'b0, 11'h000, 4'hC, 1'b1, 2'd1, n);
        check(n == 9, "R8 half", n, 9);
        issue(1'b0, 11'h000, 4'hC, 1'b1, 2'd3, n);
        check(n == 18, "R8 code3", n, 18);

        // R9: a write on the accepting edge is not seen; the next request sees it
        issue(1'b1, 11'h01C, 4'h8, 1'b0, 2'd1, n);
        check(n == 5, "R9 old value on write edge", n, 5);
        issue(1'b0, 11'h000, 4'h8, 1'b0, 2'd1, n);
        check(n == 9, "R9 new value after write", n, 9);

        // R10: the done pulse lasts one cycle and busy is clear with it
        check(!busy, "R10 busy low at done", int'(busy), 0);
        @(negedge clk);
        check(!done, "R10 done single cycle", int'(done), 0);

        // R11: a request during a count is ignored
        write_cfg(11'h000);
        @(negedge clk);
        req_valid = 1'b1; req_page = 4'hD; req_seq = 1'b1; req_width = 2'd2;
        @(negedge clk);
        req_valid = 1'b0;
        n = 0;
        while (!done && n < 40) begin
            @(negedge clk);
            n++;
            if (n == 3) begin
                req_valid = 1'b1; req_page = 4'h0; req_width = 2'd0;
            end else begin
                req_valid = 1'b0;
            end
        end
        check(n == 18, "R11 count not restarted", n, 18);
        check(cost == 5'd18, "R11 cost held", int'(cost), 18);
        @(negedge clk);
        check(!done && !busy, "R11 no extra request", int'({busy, done}), 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule